// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block connects two data buses, A and B, and is split into independent byte-wide halves. Each half can pass data live from one bus to the other, or present a value it captured earlier. Every half holds two capture registers: one takes the value seen on bus A and can later be driven onto bus B, and the other takes the value seen on bus B and can later be driven onto bus A. An active-low enable and a direction bit decide which bus a half drives, if any. A per-direction select chooses between the live value and the captured value.

The ports are not tri-state pins. Each bus has an input vector, an output vector and one drive-enable bit per half. A system that wants a true wired bus combines these outside the block. Each capture strobe is sampled on the system clock, and a register loads on the first clock edge where its strobe is seen high after being low. With both outputs disabled, a half works as a pure capture element. Both of its registers may load in the same cycle.

Top module: `xcvr_bridge`

## Requirements
- R1: A synchronous active-high reset clears both capture registers of every half to zero and clears the strobe history.
- R2: When a half's `oe_n` bit is 1, that half asserts neither `a_drive` nor `b_drive`, and its lanes of `a_out` and `b_out` read zero.
- R3: When `oe_n` is 0, `dir` = 1 makes the half drive bus B only (`b_drive` = 1). `dir` = 0 makes it drive bus A only (`a_drive` = 1).
- R4: While driving B, `sel_ab` = 0 puts the current `a_in` lanes on `b_out` in the same cycle. `sel_ab` = 1 puts the A-to-B register there.
- R5: While driving A, `sel_ba` = 0 puts the current `b_in` lanes on `a_out` in the same cycle. `sel_ba` = 1 puts the B-to-A register there.
- R6: The A-to-B register loads the A-bus value at the clock edge where `cap_ab` is first sampled high after being sampled low. A strobe held high does not load again, and without a new rising strobe the register holds.
- R7: The B-to-A register follows the same rule with `cap_ba` and the B-bus value.
- R8: With outputs disabled, both registers of a half may load in the same cycle, each from its own bus.
- R9: A register strobed while the half is driving its source bus captures the value the half drives on that bus, not the value on the input vector.
- R10: The controls of half h act only on lanes [h*8 +: 8] and on drive bit h.
- R11: While a half drives a bus, that output always equals either the live value or the stored value for that direction, including in the cycle a select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dir | input | 2 | Per-half direction: 1 = A to B, 0 = B to A |
| oe_n | input | 2 | Per-half output enable, active low |
| cap_ab | input | 2 | Per-half A-to-B capture strobe |
| cap_ba | input | 2 | Per-half B-to-A capture strobe |
| sel_ab | input | 2 | Per-half B output source: 0 live, 1 stored |
| sel_ba | input | 2 | Per-half A output source: 0 live, 1 stored |
| a_in | input | 16 | Value observed on bus A |
| a_out | output | 16 | Value driven toward bus A |
| a_drive | output | 2 | Per-half drive enable for bus A |
| b_in | input | 16 | Value observed on bus B |
| b_out | output | 16 | Value driven toward bus B |
| b_drive | output | 2 | Per-half drive enable for bus B |

## Verification
The bench holds a capture strobe high across two cycles and changes the data in between. A design that loads on the level rather than on the edge would pick up the second value. It also strobes the register whose source bus the half is itself driving. A design that captures `a_in` instead of the driven value would store the wrong byte. The bench sets the two halves to opposite directions, isolates only one half, and strobes only one half. Any leakage of control between halves then shows up as a wrong drive bit or a wrong byte. Finally, it switches the selects between live and stored values with different contents. This exposes a swapped mux or a register that reads stale data.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam logic SEL_LIVE   = 1'b0;
    localparam logic SEL_STORED = 1'b1;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    typedef struct packed {
        logic dir;
        logic oe_n;
        logic cap_ab;
        logic cap_ba;
        logic sel_ab;
        logic sel_ba;
    } half_ctrl_t;

    function automatic drive_e decode_drive(input logic oe_n, input logic dir);
        if (oe_n)
            return DRV_NONE;
        return dir ? DRV_B : DRV_A;
    endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strobe_q;
    logic load;

    assign load = strobe && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (load)
                q <= d;
        end
    end

    // R6
    edge_load_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !strobe_q) |=> (q == $past(d)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(strobe && !strobe_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  half_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drive,
    output logic         b_drive
);
    drive_e       mode;
    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;
    logic [W-1:0] to_b;
    logic [W-1:0] to_a;
    logic [W-1:0] a_bus;
    logic [W-1:0] b_bus;

    always_comb begin
        mode    = decode_drive(ctrl.oe_n, ctrl.dir);
        a_drive = (mode == DRV_A);
        b_drive = (mode == DRV_B);
        to_b    = (ctrl.sel_ab == SEL_STORED) ? ab_q : a_in;
        to_a    = (ctrl.sel_ba == SEL_STORED) ? ba_q : b_in;
        // a driven bus carries this half's own output value
        a_bus   = a_drive ? to_a : a_in;
        b_bus   = b_drive ? to_b : b_in;
        a_out   = a_drive ? to_a : '0;
        b_out   = b_drive ? to_b : '0;
    end

    xcvr_capture #(.W(W)) u_ab (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctrl.cap_ab),
        .d      (a_bus),
        .q      (ab_q)
    );

    xcvr_capture #(.W(W)) u_ba (
        .clk    (clk),
        .rst    (rst),
        .strobe (ctrl.cap_ba),
        .d      (b_bus),
        .q      (ba_q)
    );

    // R11
    b_source_chk: assert property (@(posedge clk) disable iff (rst)
        b_drive |-> (b_out == a_in || b_out == ab_q));

    // R11
    a_source_chk: assert property (@(posedge clk) disable iff (rst)
        a_drive |-> (a_out == b_in || a_out == ba_q));

    // R2
    b_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !b_drive |-> (b_out == '0));

    // R2
    a_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !a_drive |-> (a_out == '0));

endmodule

// File: rtl/xcvr_bridge.sv
module xcvr_bridge
    import xcvr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int HALVES = 2,
    localparam int BUS_W = LANE_W * HALVES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALVES-1:0] dir,
    input  logic [HALVES-1:0] oe_n,
    input  logic [HALVES-1:0] cap_ab,
    input  logic [HALVES-1:0] cap_ba,
    input  logic [HALVES-1:0] sel_ab,
    input  logic [HALVES-1:0] sel_ba,
    input  logic [BUS_W-1:0]  a_in,
    output logic [BUS_W-1:0]  a_out,
    output logic [HALVES-1:0] a_drive,
    input  logic [BUS_W-1:0]  b_in,
    output logic [BUS_W-1:0]  b_out,
    output logic [HALVES-1:0] b_drive
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        half_ctrl_t ctrl;

        assign ctrl = '{dir:    dir[h],
                        oe_n:   oe_n[h],
                        cap_ab: cap_ab[h],
                        cap_ba: cap_ba[h],
                        sel_ab: sel_ab[h],
                        sel_ba: sel_ba[h]};

        xcvr_half #(.W(LANE_W)) u_half (
            .clk     (clk),
            .rst     (rst),
            .ctrl    (ctrl),
            .a_in    (a_in[h*LANE_W +: LANE_W]),
            .b_in    (b_in[h*LANE_W +: LANE_W]),
            .a_out   (a_out[h*LANE_W +: LANE_W]),
            .b_out   (b_out[h*LANE_W +: LANE_W]),
            .a_drive (a_drive[h]),
            .b_drive (b_drive[h])
        );

        // R3
        drive_dir_chk: assert property (@(posedge clk) disable iff (rst)
            !oe_n[h] |-> (b_drive[h] == dir[h] && a_drive[h] == !dir[h]));
    end

endmodule

// File: tb/xcvr_bridge_test.sv
module xcvr_bridge_test;

    typedef struct packed {
        logic [1:0]  dir;
        logic [1:0]  oe_n;
        logic [1:0]  cab;
        logic [1:0]  cba;
        logic [1:0]  sab;
        logic [1:0]  sba;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [1:0]  eadrv;
        logic [1:0]  ebdrv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'h1234, 16'hABCD, 16'h0000, 16'h0000, 2'b00, 2'b00},
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 16'h5555, 16'h0000, 16'h0000, 16'h1234, 2'b00, 2'b11},
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h5555, 16'h0000, 16'h0000, 16'h5555, 2'b00, 2'b11},
        '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 16'hFFFF, 16'h7777, 16'hABCD, 16'h0000, 2'b11, 2'b00},
        '{2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 16'hFFFF, 16'h7777, 16'h7777, 16'h0000, 2'b11, 2'b00},
        '{2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 16'h9999, 16'h0000, 16'h0000, 16'h7777, 2'b00, 2'b11},
        '{2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 16'h9999, 16'h0000, 16'h0000, 16'h7777, 2'b00, 2'b11},
        '{2'b10, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 16'h1111, 16'h2222, 16'h0022, 16'h7700, 2'b01, 2'b10},
        '{2'b11, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 16'h3C3C, 16'h0000, 16'h0000, 16'h3C00, 2'b00, 2'b10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  dir = '0, oe_n = 2'b11, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_drive, b_drive;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xcvr_bridge uut (
        .clk(clk), .rst(rst), .dir(dir), .oe_n(oe_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R8";
            1: return "R4";
            2: return "R4";
            3: return "R5";
            4: return "R9";
            5: return "R6";
            6: return "R6";
            7: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic apply(input vec_t v);
        dir = v.dir; oe_n = v.oe_n; cap_ab = v.cab; cap_ba = v.cba;
        sel_ab = v.sab; sel_ba = v.sba; a_in = v.a; b_in = v.b;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state: stored sources read zero
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; a_in = 16'hFFFF;
        #5 check("R1 b_out after reset", b_out, 16'h0000);
        check("R3 b_drive", {14'd0, b_drive}, 16'h0003);
        @(negedge clk);
        dir = 2'b00; sel_ba = 2'b11; b_in = 16'hEEEE;
        #5 check("R1 a_out after reset", a_out, 16'h0000);
        check("R3 a_drive", {14'd0, a_drive}, 16'h0003);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            #5;
            check({vec_tag(i), " a_out"}, a_out, VECS[i].ea);
            check({vec_tag(i), " b_out"}, b_out, VECS[i].eb);
            check({vec_tag(i), " a_drive"}, {14'd0, a_drive}, {14'd0, VECS[i].eadrv});
            check({vec_tag(i), " b_drive"}, {14'd0, b_drive}, {14'd0, VECS[i].ebdrv});
        end

        // R10: strobe only half 0
        @(negedge clk);
        oe_n = 2'b11; cap_ab = 2'b01; cap_ba = 2'b00; a_in = 16'hAAAA;
        @(negedge clk);
        cap_ab = 2'b00; oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        #5 check("R10 single-half capture", b_out, 16'h77AA);

        // R7: B-to-A edge capture then hold
        @(negedge clk);
        oe_n = 2'b11; cap_ba = 2'b11; b_in = 16'h4242;
        @(negedge clk);
        b_in = 16'h1313;
        @(negedge clk);
        cap_ba = 2'b00; oe_n = 2'b00; dir = 2'b00; sel_ba = 2'b11;
        #5 check("R7 held strobe keeps first value", a_out, 16'h4242);

        // R1: reset mid-run clears stored values
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #5 check("R1 a stored cleared", a_out, 16'h0000);
        @(negedge clk);
        dir = 2'b11;
        #5 check("R1 b stored cleared", b_out, 16'h0000);

        summary();
    end

endmodule